// File: doc/BRIEF.md
# Blocking Bus Line-Fill Sequencer

This block sits on the processor side of a synchronous front-side bus that is circuit-switched. It fetches one whole cache line over a data path narrower than the line. A fill request carries a line address. The sequencer then asks for the bus and issues a single line-read command at the aligned address. It waits a fixed number of bus cycles for memory to respond. After that it collects the consecutive double-word beats into a line buffer.

Once granted, the bus stays with this sequencer until the last beat has arrived, and no second fill can overlap the first. The final beat and a one-cycle done pulse appear together. The sequencer is idle again in the following cycle, so a request held high starts arbitrating at once. With the default parameters and no waiting for the grant, a fill takes 16 bus cycles:

- 1 cycle of arbitration
- 1 command cycle
- 6 cycles of memory latency
- 8 data beats

Back-to-back fills therefore deliver 64 bytes every 16 cycles at most.

Top module: `line_fill_seq`

## Requirements
- R1: After reset, bus_req, bus_cmd_valid, fill_done and fill_busy are 0 and line_data is all zeros.
- R2: In idle, bus_req follows fill_req in the same cycle. In arbitration, bus_req stays 1 in every cycle until a cycle with bus_grant high, and no command is issued before that.
- R3: bus_cmd_valid is high for exactly one cycle, the cycle after the one in which bus_req and bus_grant were both high. During it, bus_cmd_addr equals the requested address with its low log2(64) = 6 bits cleared.
- R4: Data beats are taken only from the cycle that follows MEM_LAT (default 6) waiting cycles after the command cycle. bus_rd_valid during the wait leaves line_data unchanged.
- R5: The k-th accepted beat (k = 0..7) lands in line_data bits [64k+63:64k], so byte lanes 8k to 8k+7 hold it. The first beat returned is the lowest address of the line.
- R6: fill_done is a one-cycle pulse. It appears in the cycle after the last beat is sampled, the same cycle in which line_data first shows the complete line.
- R7: The bus is blocking. While a fill is in its command, wait or data phase, bus_req stays 0 and a fill_req is ignored. No further command appears once the fill ends unless a request is then present.
- R8: A fill granted at once, with no gaps in the data, gives fill_done 16 cycles after its arbitration cycle. If fill_req is high in that done cycle, bus_req is asserted in that same cycle.
- R9: During the data phase, a cycle with bus_rd_valid low accepts no beat and delays fill_done by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_req | input | 1 | Request to fill a line; sampled while idle |
| fill_addr | input | ADDR_W | Byte address inside the wanted line |
| fill_busy | output | 1 | A fill is in progress |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_grant | input | 1 | Bus grant from the arbiter |
| bus_cmd_valid | output | 1 | Line-read command cycle |
| bus_cmd_addr | output | ADDR_W | Line-aligned command address |
| bus_rd_valid | input | 1 | Read data beat present |
| bus_rd_data | input | 8*BEAT_BYTES | Read data beat |
| line_data | output | 8*LINE_BYTES | Assembled line buffer |
| fill_done | output | 1 | One-cycle fill completion pulse |

## Verification
Each result has a fixed place on the timeline, counted from the arbitration cycle:

- bus_req is combinational and is checked in the same cycle as its request.
- The command is due one cycle after the grant.
- The first beat may be accepted 8 cycles after arbitration.
- fill_done and the full line are due one cycle after the last beat is sampled.

Every task counts bus cycles from the arbitration cycle and samples at the falling edge in exactly those cycles. Extra grant-wait cycles and data-phase stalls are added to the count. Early beats are driven during the wait, and line_data is then compared with the previous line.

// File: rtl/line_fill_seq.sv
module line_fill_seq #(
  parameter int ADDR_W     = 32,
  parameter int BEAT_BYTES = 8,
  parameter int LINE_BYTES = 64,
  parameter int MEM_LAT    = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fill_req,
  input  logic [ADDR_W-1:0]       fill_addr,
  output logic                    fill_busy,
  output logic                    bus_req,
  input  logic                    bus_grant,
  output logic                    bus_cmd_valid,
  output logic [ADDR_W-1:0]       bus_cmd_addr,
  input  logic                    bus_rd_valid,
  input  logic [8*BEAT_BYTES-1:0] bus_rd_data,
  output logic [8*LINE_BYTES-1:0] line_data,
  output logic                    fill_done
);
  localparam int DATA_W = 8 * BEAT_BYTES;
  localparam int BEATS  = LINE_BYTES / BEAT_BYTES;
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int BCNT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int WCNT_W = (MEM_LAT > 1) ? $clog2(MEM_LAT) : 1;
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~((ADDR_W'(1) << OFF_W) - ADDR_W'(1));
  localparam logic [BCNT_W-1:0] LAST_BEAT  = BCNT_W'(BEATS - 1);
  localparam logic [WCNT_W-1:0] LAST_WAIT  = WCNT_W'(MEM_LAT - 1);

  typedef enum logic [2:0] {S_IDLE, S_ARB, S_CMD, S_WAIT, S_DATA} state_t;

  state_t                       st_q;
  logic [ADDR_W-1:0]            addr_q;
  logic [WCNT_W-1:0]            wait_q;
  logic [BCNT_W-1:0]            beat_q;
  logic                         done_q;
  logic [BEATS-1:0][DATA_W-1:0] line_q;
  logic                         beat_we;
  logic                         last_beat;

  assign bus_req       = (st_q == S_IDLE && fill_req) || st_q == S_ARB;
  assign bus_cmd_valid = st_q == S_CMD;
  assign bus_cmd_addr  = addr_q;
  assign fill_busy     = st_q != S_IDLE;
  assign fill_done     = done_q;
  assign line_data     = line_q;
  assign beat_we       = st_q == S_DATA && bus_rd_valid;
  assign last_beat     = beat_we && beat_q == LAST_BEAT;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      addr_q <= '0;
      wait_q <= '0;
      beat_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= last_beat;
      unique case (st_q)
        S_IDLE: if (fill_req) begin
          addr_q <= fill_addr & ALIGN_MASK;
          st_q   <= bus_grant ? S_CMD : S_ARB;
        end
        S_ARB:  if (bus_grant) st_q <= S_CMD;
        S_CMD: begin
          wait_q <= '0;
          st_q   <= S_WAIT;
        end
        S_WAIT: begin
          wait_q <= wait_q + WCNT_W'(1);
          if (wait_q == LAST_WAIT) begin
            beat_q <= '0;
            st_q   <= S_DATA;
          end
        end
        S_DATA: if (beat_we) begin
          beat_q <= beat_q + BCNT_W'(1);
          if (last_beat) st_q <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < BEATS; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)
        line_q[g] <= '0;
      else if (beat_we && beat_q == BCNT_W'(g))
        line_q[g] <= bus_rd_data;
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_grant) |=> (bus_req && !bus_cmd_valid)); // R2
  AST_CMD_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_cmd_valid) |-> $past(bus_req && bus_grant)); // R3
  AST_CMD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cmd_valid |=> !bus_cmd_valid); // R3
  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_WAIT) |=> $stable(line_data)); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> !fill_done); // R6
  AST_NO_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q inside {S_CMD, S_WAIT, S_DATA}) |-> !bus_req); // R7
endmodule

// File: tb/line_fill_seq_bench.sv
module line_fill_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int DW = 64;
  localparam int LW = 512;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fill_req = 1'b0;
  logic [AW-1:0] fill_addr = '0;
  logic          bus_grant = 1'b0;
  logic          bus_rd_valid = 1'b0;
  logic [DW-1:0] bus_rd_data = '0;
  logic          fill_busy, bus_req, bus_cmd_valid, fill_done;
  logic [AW-1:0] bus_cmd_addr;
  logic [LW-1:0] line_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  logic [LW-1:0] prev_line = '0;

  line_fill_seq u_line_fill_seq (
    .clk(clk), .rst_n(rst_n), .fill_req(fill_req), .fill_addr(fill_addr),
    .fill_busy(fill_busy), .bus_req(bus_req), .bus_grant(bus_grant),
    .bus_cmd_valid(bus_cmd_valid), .bus_cmd_addr(bus_cmd_addr),
    .bus_rd_valid(bus_rd_valid), .bus_rd_data(bus_rd_data),
    .line_data(line_data), .fill_done(fill_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string rq, input logic [LW-1:0] act, input logic [LW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] beat_pat(input logic [AW-1:0] a, input int k);
    return {a ^ 32'h5A5A_0000, 32'hC0DE_0000 | 32'(k)};
  endfunction

  task automatic run_fill(input logic [AW-1:0] a, input int gw, input bit stall,
                          input bit junk, input bit intrude, input bit cont,
                          input bit nxt, input logic [AW-1:0] na);
    logic [LW-1:0] exp_line;
    int n;
    n = 0;
    for (int k = 0; k < 8; k++) exp_line[k*64 +: 64] = beat_pat(a, k);
    if (!cont) begin
      @(negedge clk);
      fill_req = 1'b1; fill_addr = a; bus_grant = (gw == 0);
    end
    #1 chk("R2 req in idle", LW'(bus_req), LW'(1));
    for (int i = 0; i < gw; i++) begin
      @(negedge clk); n++;
      fill_req = 1'b0; bus_grant = (i == gw - 1);
      #1 chk("R2 req held", LW'({bus_req, bus_cmd_valid}), LW'(2'b10));
    end
    @(negedge clk); n++;
    fill_req = 1'b0; bus_grant = 1'b0;
    #1 chk("R3 cmd valid", LW'(bus_cmd_valid), LW'(1));
    chk("R3 cmd addr aligned", LW'(bus_cmd_addr), LW'(a & ~32'h3F));
    @(negedge clk); n++;
    #1 chk("R3 cmd one cycle", LW'(bus_cmd_valid), LW'(0));
    for (int j = 0; j < 6; j++) begin
      if (j > 0) begin @(negedge clk); n++; end
      bus_rd_valid = junk; bus_rd_data = {DW{1'b1}};
      fill_req = intrude && j == 2; fill_addr = intrude ? 32'hDEAD_0040 : a;
      #1;
      if (intrude && j == 2) chk("R7 no req while busy", LW'(bus_req), LW'(0));
    end
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); n++;
      fill_req = 1'b0;
      if (stall && k == 3) begin
        bus_rd_valid = 1'b0;
        @(negedge clk); n++;
      end
      bus_rd_valid = 1'b1; bus_rd_data = beat_pat(a, k);
      #1 chk("R6 no early done", LW'(fill_done), LW'(0));
      if (k == 0) chk("R4 early beats ignored", line_data, prev_line);
      if (stall && k == 3) chk("R9 stall holds beat 3", line_data[3*64 +: 64], LW'(0) | prev_line[3*64 +: 64]);
    end
    @(negedge clk); n++;
    bus_rd_valid = 1'b0; fill_req = nxt; fill_addr = na; bus_grant = nxt;
    #1 chk("R6 done pulse", LW'(fill_done), LW'(1));
    chk("R5 line assembled", line_data, exp_line);
    chk("R8 fill length", LW'(n), LW'(16 + gw + (stall ? 1 : 0)));
    if (nxt) chk("R8 next req in done cycle", LW'(bus_req), LW'(1));
    else     chk("R7 idle after fill", LW'({fill_busy, bus_req}), LW'(0));
    prev_line = exp_line;
    if (!nxt) begin
      @(negedge clk);
      #1 chk("R6 done one cycle", LW'(fill_done), LW'(0));
    end
  endtask

  task automatic t_reset();
    #1 chk("R1 reset outputs", LW'({bus_req, bus_cmd_valid, fill_done, fill_busy}), LW'(0));
    chk("R1 reset line", line_data, '0);
  endtask

  task automatic t_basic();
    run_fill(32'h1234_5678, 0, 0, 0, 0, 0, 0, '0);
  endtask

  task automatic t_grant_wait();
    run_fill(32'h0000_9FC7, 3, 0, 1, 0, 0, 0, '0);
  endtask

  task automatic t_stall();
    run_fill(32'hABCD_0101, 1, 1, 0, 0, 0, 0, '0);
  endtask

  task automatic t_blocking();
    run_fill(32'h0F0F_F0F0, 0, 0, 1, 1, 0, 0, '0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      #1 chk("R7 intruding req dropped", LW'({bus_cmd_valid, fill_busy}), LW'(0));
    end
  endtask

  task automatic t_back2back();
    run_fill(32'h4000_0008, 0, 0, 0, 0, 0, 1, 32'h4000_00C0);
    run_fill(32'h4000_00C0, 0, 0, 0, 0, 1, 0, '0);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_basic();
    t_grant_wait();
    t_stall();
    t_blocking();
    t_back2back();
    repeat (2) @(negedge clk);
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end
endmodule